// File: doc/BRIEF.md
# Static and Strobed Bidirectional Byte Port

This block is an eight-line bidirectional port for a small processor core. It works in two ways. In static use it holds a latched output byte. The core can load that byte outright, or change it by AND-ing or OR-ing it with an immediate mask. The core can also turn the port around and read the pins directly. Direction is a single choice for all eight lines. There is no per-bit direction.

In strobed use the port carries transfers to and from external data memory. A write command drives the operand onto the lines only while an active-low write strobe is low. A read command pulls an active-low read strobe low, samples the lines on the last strobe cycle and returns the byte with a one-cycle done flag. After any transfer the lines float until the core issues another static output command. While a strobe is running the port reports busy, and commands presented during that time are not taken.

The core issues commands on a command port: a valid bit, a 3-bit operation code and an 8-bit operand. The tri-state pins are modelled as a separate output value, output enable and input value. Address latching is handled elsewhere.

Top module: `bus_port`

## Requirements
- R1: After reset, rd_n_o and wr_n_o are 1, bus_oe_o is 0, busy_o is 0 and done_o is 0.
- R2: A load command (op 1) accepted at a clock edge makes bus_o equal the operand and bus_oe_o equal 1 from that edge on.
- R3: An AND command (op 2) or an OR command (op 3) replaces the latch with latch AND operand or latch OR operand, and drives it with bus_oe_o set to 1. The latch does not change on a cycle with no accepted command.
- R4: A pin-read command (op 4) sets bus_oe_o to 0. It returns the bus_i value present at the accepting edge on rdata_o, with done_o high for the next cycle.
- R5: A write-transfer command (op 6) holds wr_n_o low for STROBE_CYCLES (default 2) cycles. During exactly those cycles bus_oe_o is 1 and bus_o equals the operand.
- R6: A read-transfer command (op 5) holds rd_n_o low for STROBE_CYCLES cycles. It captures bus_i on the last low cycle and presents it on rdata_o with done_o high for the one cycle after rd_n_o returns high.
- R7: After a read or write transfer, bus_oe_o stays 0 until the next load, AND or OR command. The static latch contents survive the transfer.
- R8: busy_o is 1 whenever a strobe is low. A command presented while busy_o is 1 is ignored.
- R9: rd_n_o and wr_n_o are never low together, and bus_oe_o is 0 whenever rd_n_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 3 | Operation: 0 none, 1 load, 2 AND, 3 OR, 4 pin read, 5 read transfer, 6 write transfer |
| cmd_data_i | input | 8 | Operand or mask |
| busy_o | output | 1 | Strobe in progress; commands are not taken |
| rdata_o | output | 8 | Byte returned by a pin read or read transfer |
| done_o | output | 1 | One-cycle flag marking rdata_o valid |
| bus_i | input | 8 | Pin input value |
| bus_o | output | 8 | Pin output value |
| bus_oe_o | output | 1 | Output enable for all eight lines |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |

## Verification
The latch is driven by a load, an AND and an OR in sequence. The masks are chosen so that each step clears or sets bits the previous step left alone. A wrong operator or a lost update therefore shows a different byte. Read transfers change bus_i between the first and second strobe cycles, so sampling on the wrong cycle returns the wrong value. A static pin read uses a third distinct value. Write transfers are followed by a zero OR mask. This shows both the float after the transfer and the preserved latch. A load presented during a write strobe uses a byte that would show on the pins if it were wrongly taken.

// File: rtl/bus_port_pkg.sv
package bus_port_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_LOAD   = 3'd1,
    OP_AND    = 3'd2,
    OP_OR     = 3'd3,
    OP_SAMPLE = 3'd4,
    OP_XRD    = 3'd5,
    OP_XWR    = 3'd6
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } strobe_st_e;
endpackage

// File: rtl/bus_port_latch.sv
module bus_port_latch
  import bus_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         accept_i,
  input  op_e          op_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] latch_o,
  output logic         drive_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= '1;
      drive_o <= 1'b0;
    end else if (accept_i) begin
      unique case (op_i)
        OP_LOAD: begin latch_o <= data_i;           drive_o <= 1'b1; end
        OP_AND:  begin latch_o <= latch_o & data_i; drive_o <= 1'b1; end
        OP_OR:   begin latch_o <= latch_o | data_i; drive_o <= 1'b1; end
        OP_SAMPLE, OP_XRD, OP_XWR: drive_o <= 1'b0;
        default: ;
      endcase
    end
  end

  p_latch_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(latch_o));
endmodule

// File: rtl/bus_port_strobe.sv
module bus_port_strobe
  import bus_port_pkg::*;
#(
  parameter int W             = 8,
  parameter int STROBE_CYCLES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_rd_i,
  input  logic         start_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         rd_n_o,
  output logic         wr_n_o,
  output logic         busy_o,
  output logic         wr_drive_o,
  output logic [W-1:0] wdata_o,
  output logic         rd_last_o
);
  localparam int CW = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STROBE_CYCLES - 1);

  strobe_st_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wdata_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start_wr_i) begin
            state_q <= ST_WR;
            wdata_o <= wdata_i;
          end else if (start_rd_i) begin
            state_q <= ST_RD;
          end
        end
        default: begin
          if (last) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign rd_n_o     = (state_q != ST_RD);
  assign wr_n_o     = (state_q != ST_WR);
  assign busy_o     = (state_q != ST_IDLE);
  assign wr_drive_o = (state_q == ST_WR);
  assign rd_last_o  = (state_q == ST_RD) && last;

  p_start_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_rd_i || start_wr_i) |-> !busy_o);
  p_wr_data_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_n_o && $past(!wr_n_o)) |-> $stable(wdata_o));
endmodule

// File: rtl/bus_port.sv
module bus_port
  import bus_port_pkg::*;
#(
  parameter int W             = 8,
  parameter int STROBE_CYCLES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmd_valid_i,
  input  logic [2:0]   cmd_op_i,
  input  logic [W-1:0] cmd_data_i,
  output logic         busy_o,
  output logic [W-1:0] rdata_o,
  output logic         done_o,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] bus_o,
  output logic         bus_oe_o,
  output logic         rd_n_o,
  output logic         wr_n_o
);
  op_e          op;
  logic         accept;
  logic [W-1:0] latch;
  logic         drive;
  logic         wr_drive;
  logic [W-1:0] wdata;
  logic         rd_last;
  logic         sample_now;

  assign op         = op_e'(cmd_op_i);
  assign accept     = cmd_valid_i && !busy_o;
  assign sample_now = accept && (op == OP_SAMPLE);

  bus_port_latch #(.W(W)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .op_i    (op),
    .data_i  (cmd_data_i),
    .latch_o (latch),
    .drive_o (drive)
  );

  bus_port_strobe #(.W(W), .STROBE_CYCLES(STROBE_CYCLES)) u_strobe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_rd_i(accept && (op == OP_XRD)),
    .start_wr_i(accept && (op == OP_XWR)),
    .wdata_i   (cmd_data_i),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o),
    .busy_o    (busy_o),
    .wr_drive_o(wr_drive),
    .wdata_o   (wdata),
    .rd_last_o (rd_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= sample_now || rd_last;
      if (sample_now || rd_last) rdata_o <= bus_i;
    end
  end

  assign bus_oe_o = wr_drive || drive;
  assign bus_o    = wr_drive ? wdata : latch;

  p_strobe_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));
  p_no_oe_on_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> !bus_oe_o);
  p_rd_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_n_o) |-> done_o);
  p_busy_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !wr_n_o) |-> busy_o);
  p_wr_oe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_o |-> bus_oe_o);
endmodule

// File: tb/bus_port_test.sv
module bus_port_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_data = 8'h00;
  logic [7:0] bus_in = 8'h00;
  logic       busy, done, oe, rd_n, wr_n;
  logic [7:0] rdata, bus_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  bus_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_data_i(cmd_data), .busy_o(busy), .rdata_o(rdata), .done_o(done),
    .bus_i(bus_in), .bus_o(bus_out), .bus_oe_o(oe), .rd_n_o(rd_n), .wr_n_o(wr_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: returns at the negedge just after the accepting edge
  task automatic issue(input logic [2:0] op, input logic [7:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && done) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4/R6: unexpected done, actual=%h expected=none", rdata);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL R4/R6: rdata actual=%h expected=%h", rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic write_xfer(input logic [7:0] d, input string req);
    int low;
    issue(3'd6, d);
    low = 0;
    while (!wr_n && low < 10) begin
      chk({req, " oe during wr"}, {7'd0, oe}, 8'd1);
      chk({req, " data during wr"}, bus_out, d);
      chk("R9 rd_n during wr", {7'd0, rd_n}, 8'd1);
      low++;
      @(negedge clk);
    end
    chk({req, " wr_n low cycles"}, 8'(low), 8'd2);
    chk("R7 float after wr", {7'd0, oe}, 8'd0);
  endtask

  task automatic read_xfer(input logic [7:0] a, input logic [7:0] b);
    int low;
    exp_q.push_back(b);
    issue(3'd5, 8'h00);
    low = 0;
    while (!rd_n && low < 10) begin
      chk("R9 oe during rd", {7'd0, oe}, 8'd0);
      chk("R8 busy during rd", {7'd0, busy}, 8'd1);
      bus_in = (low == 0) ? a : b;
      low++;
      @(negedge clk);
    end
    chk("R6 rd_n low cycles", 8'(low), 8'd2);
    chk("R6 done after rd", {7'd0, done}, 8'd1);
    chk("R7 float after rd", {7'd0, oe}, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rd_n", {7'd0, rd_n}, 8'd1);
    chk("R1 wr_n", {7'd0, wr_n}, 8'd1);
    chk("R1 oe", {7'd0, oe}, 8'd0);
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 done", {7'd0, done}, 8'd0);
    rst_ni = 1'b1;

    // R2 load
    issue(3'd1, 8'hA5);
    chk("R2 oe", {7'd0, oe}, 8'd1);
    chk("R2 bus", bus_out, 8'hA5);
    // R3 and/or
    issue(3'd2, 8'h0F);
    chk("R3 and", bus_out, 8'h05);
    issue(3'd3, 8'h30);
    chk("R3 or", bus_out, 8'h35);
    chk("R3 oe", {7'd0, oe}, 8'd1);
    repeat (2) @(negedge clk);
    chk("R3 hold idle", bus_out, 8'h35);

    // R4 pin read
    bus_in = 8'h5C;
    exp_q.push_back(8'h5C);
    issue(3'd4, 8'h00);
    chk("R4 done", {7'd0, done}, 8'd1);
    chk("R4 oe off", {7'd0, oe}, 8'd0);
    @(negedge clk);
    chk("R4 done one cycle", {7'd0, done}, 8'd0);

    // R5 write, R7 latch preserved
    issue(3'd3, 8'h00);
    write_xfer(8'h3C, "R5");
    repeat (2) @(negedge clk);
    chk("R7 still floating", {7'd0, oe}, 8'd0);
    issue(3'd3, 8'h00);
    chk("R7 latch kept", bus_out, 8'h35);
    chk("R7 oe restored", {7'd0, oe}, 8'd1);

    // R6 reads, sampled on last strobe cycle
    read_xfer(8'h11, 8'h9E);
    read_xfer(8'hE7, 8'h42);

    // R8 command during strobe ignored
    issue(3'd6, 8'h77);
    chk("R8 busy", {7'd0, busy}, 8'd1);
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_data = 8'h00;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    chk("R8 wr data unchanged", bus_out, 8'h77);
    @(negedge clk);
    chk("R8 wr ended", {7'd0, wr_n}, 8'd1);
    chk("R8 no load taken", {7'd0, oe}, 8'd0);
    issue(3'd3, 8'h00);
    chk("R8 latch unchanged", bus_out, 8'h35);

    repeat (3) @(negedge clk);
    chk("R6 scoreboard drained", 8'(exp_q.size()), 8'd0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule